// File: doc/BRIEF.md
# CAN Controller Interrupt Request Aggregator

This block gathers every interrupt-causing event of one CAN controller into sticky flags and drives interrupt request lines from them. The event inputs are single-cycle pulses: a transmit-done and a receive-done pulse for each message slot, and pulses for a detected bus error, for entry to error-passive and for entry to bus-off. Software reads the flags on the flag outputs and clears them with write-one-to-clear pulses. Each slot has its own transmit and receive enable. A flag whose enable is 0 is still recorded, but it raises no request.

A routing select chooses between two layouts of the three request lines. In merged layout, line 0 carries the OR of all enabled sources and lines 1 and 2 stay low. In split layout, line 0 carries transmit completions, line 1 carries receive completions, and line 2 carries the error group. The error group is the OR of the bus-error interrupt flag, the error-passive flag and the bus-off flag.

A separate active-low wake-up pin is synchronized inside the block. A falling edge on it sets a wake-up flag, and that flag drives its own request output only when the wake-up enable is 1.

Top module: `can_irq_aggregator`

## Requirements
- R1: A transmit-done pulse on slot k sets tx_flag_o[k] on the next clock, and the flag stays set until a tx_clr_i[k] pulse clears it.
- R2: A receive-done pulse on slot k sets rx_flag_o[k] on the next clock, and the flag stays set until an rx_clr_i[k] pulse clears it.
- R3: A bus-error pulse sets both err_flag_o[0] (bus-error interrupt flag) and err_flag_o[3] (bus-error status flag) on the same clock.
- R4: An error-passive pulse sets err_flag_o[1] and a bus-off pulse sets err_flag_o[2]. Each err_clr_i bit clears the err_flag_o bit at the same position.
- R5: When a set pulse and a clear pulse reach the same flag in the same cycle, the flag is 1 afterwards.
- R6: With route_sep_i = 0, irq_o[0] is the OR of the enabled transmit flags, the enabled receive flags and the error group, and irq_o[2:1] is 0.
- R7: With route_sep_i = 1, irq_o[0] is the OR of the enabled transmit flags, irq_o[1] is the OR of the enabled receive flags, and irq_o[2] is the error group (err_flag_o[0] | err_flag_o[1] | err_flag_o[2]).
- R8: The bus-error status flag err_flag_o[3] on its own raises no request.
- R9: A slot flag whose enable bit (tx_en_i[k] or rx_en_i[k]) is 0 is still set, but it raises no request.
- R10: Every request output is registered. It changes one clock after the flag or the control input it depends on.
- R11: A falling edge on wake_n_i sets wake_flag_o three clocks after the pin changes. A rising edge sets nothing. wake_clr_i clears the flag.
- R12: wake_irq_o follows wake_flag_o one clock later when wake_en_i is 1, and is 0 when wake_en_i is 0.
- R13: After reset, every flag and every request output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done_i | input | 16 | Per-slot transmit-complete pulses |
| rx_done_i | input | 16 | Per-slot receive-complete pulses |
| bus_err_i | input | 1 | Bus error detected pulse |
| err_passive_i | input | 1 | Entry to error-passive pulse |
| bus_off_i | input | 1 | Entry to bus-off pulse |
| wake_n_i | input | 1 | Asynchronous active-low wake-up pin |
| route_sep_i | input | 1 | 0 = merged request, 1 = split tx/rx/error requests |
| tx_en_i | input | 16 | Per-slot transmit interrupt enables |
| rx_en_i | input | 16 | Per-slot receive interrupt enables |
| wake_en_i | input | 1 | Wake-up request enable |
| tx_clr_i | input | 16 | Write-one-to-clear for the transmit flags |
| rx_clr_i | input | 16 | Write-one-to-clear for the receive flags |
| err_clr_i | input | 4 | Write-one-to-clear for the error flags, by bit |
| wake_clr_i | input | 1 | Write-one-to-clear for the wake-up flag |
| tx_flag_o | output | 16 | Sticky transmit-done flags |
| rx_flag_o | output | 16 | Sticky receive-done flags |
| err_flag_o | output | 4 | Bit 0 bus-error interrupt, bit 1 error-passive, bit 2 bus-off, bit 3 bus-error status |
| wake_flag_o | output | 1 | Sticky wake-up flag |
| irq_o | output | 3 | Request lines, laid out by route_sep_i |
| wake_irq_o | output | 1 | Gated wake-up request |

## Verification
An event pulse sampled at clock edge k shows on its flag after edge k. The matching request shows after edge k+1. A clear behaves the same way: the flag drops after one edge and the request after two. A wake-up pin change needs three edges to reach the flag and four to reach wake_irq_o. The bench drives inputs on the falling clock edge and reads each output at the falling edge that follows the last register on its path. Before that point it also checks that the value has not yet changed.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int unsigned ERR_W  = 4;
    localparam int unsigned LINE_W = 3;

    typedef enum logic {
        ROUTE_MERGED = 1'b0,
        ROUTE_SPLIT  = 1'b1
    } route_e;

    // error flag layout: bit 0 irq, 1 passive, 2 bus-off, 3 status
    typedef struct packed {
        logic berr_sts;
        logic bus_off;
        logic err_passive;
        logic berr_irq;
    } err_flags_t;

    typedef struct packed {
        logic err;
        logic rx;
        logic tx;
    } irq_group_t;

    function automatic logic err_group(err_flags_t f);
        return f.berr_irq | f.err_passive | f.bus_off;
    endfunction

    function automatic logic [LINE_W-1:0] route_lines(route_e mode, irq_group_t g);
        logic [LINE_W-1:0] lines;
        if (mode == ROUTE_SPLIT) lines = {g.err, g.rx, g.tx};
        else                     lines = {2'b00, (g.err | g.rx | g.tx)};
        return lines;
    endfunction

endpackage

// File: rtl/can_irq_sticky.sv
module can_irq_sticky #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= (q_o & ~clr_i) | set_i;
    end

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

    // R1
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((q_o & ~clr_i) != '0) |=> ((q_o & $past(q_o & ~clr_i)) == $past(q_o & ~clr_i)));

endmodule

// File: rtl/can_irq_wake.sv
module can_irq_wake #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_i,
    input  logic clr_i,
    output logic flag_o
);

    localparam int unsigned CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;
    logic             fell;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[CHAIN-2:0], pin_n_i};
    end

    assign fell = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];

    always_ff @(posedge clk) begin
        if (rst) flag_o <= 1'b0;
        else     flag_o <= (flag_o & ~clr_i) | fell;
    end

    // R11
    wake_edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
        fell |=> flag_o);

    // R11
    wake_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag_o && !fell) |=> !flag_o);

endmodule

// File: rtl/can_irq_router.sv
module can_irq_router
    import can_irq_pkg::*;
#(
    parameter int unsigned N_SLOTS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  route_e               mode_i,
    input  logic [N_SLOTS-1:0]   tx_flag_i,
    input  logic [N_SLOTS-1:0]   tx_en_i,
    input  logic [N_SLOTS-1:0]   rx_flag_i,
    input  logic [N_SLOTS-1:0]   rx_en_i,
    input  err_flags_t           err_i,
    input  logic                 wake_flag_i,
    input  logic                 wake_en_i,
    output logic [LINE_W-1:0]    irq_o,
    output logic                 wake_irq_o
);

    irq_group_t grp;

    always_comb begin
        grp.tx  = |(tx_flag_i & tx_en_i);
        grp.rx  = |(rx_flag_i & rx_en_i);
        grp.err = err_group(err_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o      <= '0;
            wake_irq_o <= 1'b0;
        end else begin
            irq_o      <= route_lines(mode_i, grp);
            wake_irq_o <= wake_flag_i & wake_en_i;
        end
    end

    // R6
    merged_upper_low_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == ROUTE_MERGED) |=> (irq_o[2:1] == 2'b00));

    // R7
    split_err_line_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode_i == ROUTE_SPLIT) && (err_i.bus_off || err_i.err_passive || err_i.berr_irq))
        |=> irq_o[2]);

    // R9
    split_tx_masked_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode_i == ROUTE_SPLIT) && ((tx_flag_i & tx_en_i) == '0)) |=> !irq_o[0]);

    // R12
    wake_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !wake_en_i |=> !wake_irq_o);

endmodule

// File: rtl/can_irq_aggregator.sv
module can_irq_aggregator
    import can_irq_pkg::*;
#(
    parameter int unsigned N_SLOTS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_SLOTS-1:0]  tx_done_i,
    input  logic [N_SLOTS-1:0]  rx_done_i,
    input  logic                bus_err_i,
    input  logic                err_passive_i,
    input  logic                bus_off_i,
    input  logic                wake_n_i,
    input  logic                route_sep_i,
    input  logic [N_SLOTS-1:0]  tx_en_i,
    input  logic [N_SLOTS-1:0]  rx_en_i,
    input  logic                wake_en_i,
    input  logic [N_SLOTS-1:0]  tx_clr_i,
    input  logic [N_SLOTS-1:0]  rx_clr_i,
    input  logic [ERR_W-1:0]    err_clr_i,
    input  logic                wake_clr_i,
    output logic [N_SLOTS-1:0]  tx_flag_o,
    output logic [N_SLOTS-1:0]  rx_flag_o,
    output logic [ERR_W-1:0]    err_flag_o,
    output logic                wake_flag_o,
    output logic [LINE_W-1:0]   irq_o,
    output logic                wake_irq_o
);

    err_flags_t err_set;
    err_flags_t err_q;

    always_comb begin
        err_set.berr_sts    = bus_err_i;
        err_set.bus_off     = bus_off_i;
        err_set.err_passive = err_passive_i;
        err_set.berr_irq    = bus_err_i;
    end

    can_irq_sticky #(.W(N_SLOTS)) u_tx (
        .clk(clk), .rst(rst), .set_i(tx_done_i), .clr_i(tx_clr_i), .q_o(tx_flag_o)
    );

    can_irq_sticky #(.W(N_SLOTS)) u_rx (
        .clk(clk), .rst(rst), .set_i(rx_done_i), .clr_i(rx_clr_i), .q_o(rx_flag_o)
    );

    can_irq_sticky #(.W(ERR_W)) u_err (
        .clk(clk), .rst(rst), .set_i(err_set), .clr_i(err_clr_i), .q_o(err_q)
    );

    assign err_flag_o = err_q;

    can_irq_wake #(.SYNC_STAGES(2)) u_wake (
        .clk(clk), .rst(rst), .pin_n_i(wake_n_i), .clr_i(wake_clr_i), .flag_o(wake_flag_o)
    );

    can_irq_router #(.N_SLOTS(N_SLOTS)) u_route (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (route_e'(route_sep_i)),
        .tx_flag_i  (tx_flag_o),
        .tx_en_i    (tx_en_i),
        .rx_flag_i  (rx_flag_o),
        .rx_en_i    (rx_en_i),
        .err_i      (err_q),
        .wake_flag_i(wake_flag_o),
        .wake_en_i  (wake_en_i),
        .irq_o      (irq_o),
        .wake_irq_o (wake_irq_o)
    );

    // R3
    berr_both_flags_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err_i |=> (err_flag_o[0] && err_flag_o[3]));

    // R4
    bus_off_flag_chk: assert property (@(posedge clk) disable iff (rst)
        bus_off_i |=> err_flag_o[2]);

endmodule

// File: tb/can_irq_aggregator_test.sv
module can_irq_aggregator_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  tx_done = '0, rx_done = '0;
    logic          bus_err = 0, err_passive = 0, bus_off = 0;
    logic          wake_n = 1'b1, route_sep = 0;
    logic [N-1:0]  tx_en = '0, rx_en = '0;
    logic          wake_en = 0;
    logic [N-1:0]  tx_clr = '0, rx_clr = '0;
    logic [3:0]    err_clr = '0;
    logic          wake_clr = 0;
    logic [N-1:0]  tx_flag, rx_flag;
    logic [3:0]    err_flag;
    logic          wake_flag;
    logic [2:0]    irq;
    logic          wake_irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    can_irq_aggregator #(.N_SLOTS(N)) uut (
        .clk(clk), .rst(rst),
        .tx_done_i(tx_done), .rx_done_i(rx_done),
        .bus_err_i(bus_err), .err_passive_i(err_passive), .bus_off_i(bus_off),
        .wake_n_i(wake_n), .route_sep_i(route_sep),
        .tx_en_i(tx_en), .rx_en_i(rx_en), .wake_en_i(wake_en),
        .tx_clr_i(tx_clr), .rx_clr_i(rx_clr), .err_clr_i(err_clr), .wake_clr_i(wake_clr),
        .tx_flag_o(tx_flag), .rx_flag_o(rx_flag), .err_flag_o(err_flag),
        .wake_flag_o(wake_flag), .irq_o(irq), .wake_irq_o(wake_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [2:0] exp_line(int kind, bit sep);
        // kind 0 tx, 1 rx, 2 error group
        if (!sep) return 3'b001;
        return 3'b001 << kind;
    endfunction

    // one slot event: pulse, check flag, check irq, clear, check both drop
    task automatic slot_run(int kind, int idx, bit en, bit sep);
        logic [N-1:0] one;
        logic [2:0]   e;
        one = N'(1) << idx;
        route_sep = sep;
        tx_en = en ? '1 : '0;
        rx_en = en ? '1 : '0;
        step(); step();
        if (kind == 0) tx_done = one; else rx_done = one;
        step();
        tx_done = '0; rx_done = '0;
        if (kind == 0) chk("R1 tx flag set", tx_flag, one);
        else           chk("R2 rx flag set", rx_flag, one);
        chk("R10 irq not yet", irq, 3'b000);
        step();
        e = en ? exp_line(kind, sep) : 3'b000;
        if (en) chk(sep ? "R7 split line" : "R6 merged line", irq, e);
        else    chk("R9 disabled slot no irq", irq, e);
        step(); step();
        if (kind == 0) chk("R1 tx flag sticky", tx_flag, one);
        else           chk("R2 rx flag sticky", rx_flag, one);
        if (kind == 0) tx_clr = one; else rx_clr = one;
        step();
        tx_clr = '0; rx_clr = '0;
        if (kind == 0) chk("R1 tx flag cleared", tx_flag, '0);
        else           chk("R2 rx flag cleared", rx_flag, '0);
        step();
        chk("R10 irq drops after clear", irq, 3'b000);
    endtask

    task automatic err_run(int which, bit sep);
        logic [3:0] ef;
        route_sep = sep;
        step(); step();
        case (which)
            0: begin bus_err = 1; ef = 4'b1001; end
            1: begin err_passive = 1; ef = 4'b0010; end
            default: begin bus_off = 1; ef = 4'b0100; end
        endcase
        step();
        bus_err = 0; err_passive = 0; bus_off = 0;
        chk(which == 0 ? "R3 bus error flags" : "R4 error flags", err_flag, ef);
        step();
        chk(sep ? "R7 error line" : "R6 merged error", irq, exp_line(2, sep));
        if (which == 0) begin
            err_clr = 4'b0001;
            step();
            err_clr = '0;
            chk("R4 clear irq bit only", err_flag, 4'b1000);
            step();
            chk("R8 status flag alone no irq", irq, 3'b000);
            err_clr = 4'b1000;
            step();
            err_clr = '0;
        end else begin
            err_clr = ef;
            step();
            err_clr = '0;
        end
        chk("R4 error flags cleared", err_flag, 4'b0000);
        step();
        chk("R10 irq drops", irq, 3'b000);
    endtask

    task automatic wake_run(bit en);
        wake_en = en;
        step(); step();
        wake_n = 0;               // change before edge k
        step();                   // after k
        step();                   // after k+1
        chk("R11 wake flag not yet", wake_flag, 1'b0);
        step();                   // after k+2
        chk("R11 wake flag set", wake_flag, 1'b1);
        chk("R12 wake irq not yet", wake_irq, 1'b0);
        step();                   // after k+3
        chk("R12 wake irq gated", wake_irq, en);
        wake_clr = 1;
        step();
        wake_clr = 0;
        chk("R11 wake flag cleared", wake_flag, 1'b0);
        wake_n = 1;               // rising edge must not set
        repeat (5) step();
        chk("R11 rising edge ignored", wake_flag, 1'b0);
        chk("R12 wake irq low", wake_irq, 1'b0);
    endtask

    initial begin
        repeat (3) step();
        rst = 0;
        step();
        chk("R13 reset tx flags", tx_flag, '0);
        chk("R13 reset rx flags", rx_flag, '0);
        chk("R13 reset err flags", err_flag, '0);
        chk("R13 reset wake", {wake_flag, wake_irq}, 2'b00);
        chk("R13 reset irq", irq, 3'b000);

        for (int s = 0; s < 2; s++)
            for (int en = 0; en < 2; en++)
                for (int k = 0; k < 2; k++)
                    for (int i = 0; i < N; i++)
                        slot_run(k, i, en[0], s[0]);

        for (int s = 0; s < 2; s++)
            for (int w = 0; w < 3; w++)
                err_run(w, s[0]);

        // R5: set and clear together, from clear and from set states
        tx_en = '1; rx_en = '1; route_sep = 1;
        tx_done[5] = 1; tx_clr[5] = 1;
        step();
        tx_done = '0; tx_clr = '0;
        chk("R5 set beats clear (idle)", tx_flag, 32'h0020);
        rx_done[9] = 1;
        step();
        rx_done = '0;
        rx_done[9] = 1; rx_clr[9] = 1;
        step();
        rx_done = '0; rx_clr = '0;
        chk("R5 set beats clear (set)", rx_flag, 32'h0200);
        chk("R7 tx and rx lines", irq, 3'b011);
        route_sep = 0;
        step();
        chk("R6 merged, upper lines low", irq, 3'b001);
        // R9: mask one slot while another remains
        tx_en = '0;
        step(); step();
        chk("R9 rx still raises merged", irq, 3'b001);
        rx_en = ~(N'(1) << 9);
        step(); step();
        chk("R9 masked slot drops request", irq, 3'b000);
        chk("R9 flags kept while masked", {tx_flag, rx_flag}, {16'h0020, 16'h0200});
        tx_clr = '1; rx_clr = '1;
        step();
        tx_clr = '0; rx_clr = '0;
        chk("R1 all cleared", {tx_flag, rx_flag}, 32'h0);

        wake_run(1'b0);
        wake_run(1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule